// File: doc/BRIEF.md
# Pipeline hazard controller

This block decides, every cycle, whether the front of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) must hold still or throw work away. It covers three hazards. The first is a load whose result is needed by the very next instruction. The second is a conditional jump that was predicted taken but turns out not taken. The third is a return instruction, whose target address is only known late. It also covers the cases where two of these hazards land in the same cycle. The decision logic is purely combinational on the current pipeline contents. A thin wrapper holds the decode, execute and memory-stage instruction registers, and applies the hold or flush at the next rising clock edge.

The fetch stage is outside the block. The caller presents the fetched instruction on the `f_*` inputs and must present the same instruction again in any cycle where `f_stall` was high at the clock edge. Forwarding, the datapath and next-PC selection are not part of this block.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: Operation codes are 4 bits: 0x1 no-op, 0x5 memory load, 0xB pop, 0x7 conditional jump, 0x9 return; any other code is an ordinary operation. Register number 0xF means "no register". A flushed stage holds op 0x1 with every register field 0xF.
- R2: A load/use hazard exists when execute holds a load or pop whose memory destination is not 0xF and equals either decode source register. In that cycle f_stall, d_stall and e_bubble are 1.
- R3: When d_stall is 1 at a clock edge, the decode register keeps its instruction; when e_bubble is 1, execute receives a no-op at that edge.
- R4: A mispredicted jump (execute holds op 0x7 while e_cnd is 0) drives d_bubble and e_bubble to 1 and d_stall to 0, so both younger instructions become no-ops at the next edge.
- R5: While a return sits in decode, execute or memory, f_stall is 1 and, with no load/use hazard, d_bubble is 1. A lone return therefore stalls fetch for three consecutive cycles.
- R6: When a return in decode meets a load/use hazard, d_bubble is 0 and d_stall is 1, so the return stays in decode one extra cycle before its three stall cycles.
- R7: A not-taken jump in execute with a return behind it in decode gives f_stall, d_bubble and e_bubble all 1. The return is cancelled, and the cycle after has no stall or bubble.
- R8: d_stall and d_bubble are never 1 in the same cycle.
- R9: e_cnd has no effect unless execute holds a jump. The memory-stage op always takes the execute op at each edge.
- R10: During synchronous active-low reset, all three stage registers load the flushed value of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| f_op | input | 4 | Op code of the fetched instruction |
| f_src_a | input | 4 | First source register of the fetched instruction |
| f_src_b | input | 4 | Second source register of the fetched instruction |
| f_dst_m | input | 4 | Memory-result destination of the fetched instruction |
| e_cnd | input | 1 | Branch outcome for the jump now in execute (1 = taken) |
| f_stall | output | 1 | Fetch must re-present the same instruction next cycle |
| d_stall | output | 1 | Decode register holds at the next edge |
| d_bubble | output | 1 | Decode register loads a no-op at the next edge |
| e_bubble | output | 1 | Execute register loads a no-op at the next edge |
| d_op | output | 4 | Op code now in decode |
| e_op | output | 4 | Op code now in execute |
| m_op | output | 4 | Op code now in memory |

## Verification
The hardest situations to reach are the two coincidences. In the first, a load into register 4 is followed at once by a return that reads register 4. In the second, a not-taken jump is followed at once by a return. Neither can be forced directly from the ports, because the controller only reacts to what has already moved into decode and execute. The bench therefore feeds these exact instruction pairs back to back after a reset, and checks the control outputs in each of the following cycles with literal expected values. It also runs a longer instruction stream, acting as fetch by honouring f_stall, against a reference pipeline model that it updates every cycle.

// File: rtl/hzd_pkg.sv
// Shared widths, op codes and the flushed instruction value for the
// pipeline hazard controller. Assumes 4-bit op codes and register numbers.
package hzd_pkg;
    localparam int OP_W  = 4;
    localparam int REG_W = 4;
    localparam int NSTG  = 3;   // stages scanned for a return: D, E, M

    typedef logic [OP_W-1:0]  op_t;
    typedef logic [REG_W-1:0] reg_t;

    localparam op_t OP_NOP  = op_t'(4'h1);
    localparam op_t OP_LOAD = op_t'(4'h5);
    localparam op_t OP_POP  = op_t'(4'hB);
    localparam op_t OP_JCC  = op_t'(4'h7);
    localparam op_t OP_RET  = op_t'(4'h9);
    localparam reg_t REG_NONE = '1;

    typedef struct packed {
        op_t  op;
        reg_t src_a;
        reg_t src_b;
        reg_t dst_m;
    } instr_t;

    localparam int INSTR_W = $bits(instr_t);
    localparam instr_t INSTR_NOP = '{op: OP_NOP, src_a: REG_NONE,
                                     src_b: REG_NONE, dst_m: REG_NONE};
endpackage

// File: rtl/hzd_ctl.sv
// Combinational hazard decision. It looks at the ops in D, E and M, the
// decode sources, the execute memory destination and the branch outcome.
// Its outputs take effect at the next clock edge in the wrapper.
// Assumes that only loads and pops write a memory result.
module hzd_ctl
    import hzd_pkg::*;
(
    input  op_t  d_op,
    input  op_t  e_op,
    input  op_t  m_op,
    input  reg_t d_src_a,
    input  reg_t d_src_b,
    input  reg_t e_dst_m,
    input  logic e_cnd,
    output logic f_stall,
    output logic d_stall,
    output logic d_bubble,
    output logic e_bubble
);
    op_t             stage_op [NSTG];
    logic [NSTG-1:0] ret_hit;
    logic            load_use;
    logic            mispredict;
    logic            ret_busy;

    assign stage_op[0] = d_op;
    assign stage_op[1] = e_op;
    assign stage_op[2] = m_op;

    // One return detector per scanned stage
    for (genvar s = 0; s < NSTG; s++) begin : g_ret
        assign ret_hit[s] = (stage_op[s] == OP_RET);
    end

    // Classify the hazards present this cycle
    always_comb begin
        load_use   = ((e_op == OP_LOAD) || (e_op == OP_POP))
                     && (e_dst_m != REG_NONE)
                     && ((e_dst_m == d_src_a) || (e_dst_m == d_src_b));
        mispredict = (e_op == OP_JCC) && !e_cnd;
        ret_busy   = |ret_hit;
    end

    // Combine hazards; load/use wins over the return's decode bubble
    always_comb begin
        f_stall  = load_use || ret_busy;
        d_stall  = load_use;
        d_bubble = mispredict || (ret_busy && !load_use);
        e_bubble = mispredict || load_use;
    end
endmodule

// File: rtl/hzd_stage_reg.sv
// One pipeline register with hold and flush. A flush loads EMPTY and wins
// over hold; the controller never asks for both at once.
module hzd_stage_reg #(
    parameter int          W     = 8,
    parameter logic [W-1:0] EMPTY = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         flush,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    // Reset, flush, hold or load at each rising edge
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= EMPTY;
        else if (flush)  q <= EMPTY;
        else if (!hold)  q <= din;
    end
endmodule

// File: rtl/pipe_hazard_ctl.sv
// Top: decode, execute and memory instruction registers driven by the
// hazard decision. Fetch is outside; the caller re-presents the fetched
// instruction after any cycle with f_stall high.
module pipe_hazard_ctl
    import hzd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] f_op,
    input  logic [REG_W-1:0] f_src_a,
    input  logic [REG_W-1:0] f_src_b,
    input  logic [REG_W-1:0] f_dst_m,
    input  logic            e_cnd,
    output logic            f_stall,
    output logic            d_stall,
    output logic            d_bubble,
    output logic            e_bubble,
    output logic [OP_W-1:0] d_op,
    output logic [OP_W-1:0] e_op,
    output logic [OP_W-1:0] m_op
);
    localparam int E_W = OP_W + REG_W;
    localparam logic [E_W-1:0] E_EMPTY = {OP_NOP, REG_NONE};

    instr_t          f_ins;
    instr_t          d_q;
    logic [E_W-1:0]  e_q;
    logic [OP_W-1:0] m_q;

    assign f_ins = '{op: f_op, src_a: f_src_a, src_b: f_src_b, dst_m: f_dst_m};

    hzd_stage_reg #(.W(INSTR_W), .EMPTY(INSTR_NOP)) u_dreg (
        .clk(clk), .rst_n(rst_n), .hold(d_stall), .flush(d_bubble),
        .din(f_ins), .q(d_q)
    );

    hzd_stage_reg #(.W(E_W), .EMPTY(E_EMPTY)) u_ereg (
        .clk(clk), .rst_n(rst_n), .hold(1'b0), .flush(e_bubble),
        .din({d_q.op, d_q.dst_m}), .q(e_q)
    );

    hzd_stage_reg #(.W(OP_W), .EMPTY(OP_NOP)) u_mreg (
        .clk(clk), .rst_n(rst_n), .hold(1'b0), .flush(1'b0),
        .din(e_q[E_W-1 -: OP_W]), .q(m_q)
    );

    hzd_ctl u_ctl (
        .d_op(d_q.op), .e_op(e_q[E_W-1 -: OP_W]), .m_op(m_q),
        .d_src_a(d_q.src_a), .d_src_b(d_q.src_b),
        .e_dst_m(e_q[REG_W-1:0]), .e_cnd(e_cnd),
        .f_stall(f_stall), .d_stall(d_stall),
        .d_bubble(d_bubble), .e_bubble(e_bubble)
    );

    assign d_op = d_q.op;
    assign e_op = e_q[E_W-1 -: OP_W];
    assign m_op = m_q;
endmodule

// File: rtl/hzd_chk.sv
// Assertion checker for pipe_hazard_ctl, attached by bind below.
module hzd_chk
    import hzd_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            e_cnd,
    input logic            f_stall,
    input logic            d_stall,
    input logic            d_bubble,
    input logic            e_bubble,
    input logic [OP_W-1:0] d_op,
    input logic [OP_W-1:0] e_op,
    input logic [OP_W-1:0] m_op
);
    // R8
    d_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(d_stall && d_bubble));
    // R3
    d_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_stall |=> (d_op == $past(d_op)));
    // R3
    e_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        e_bubble |=> (e_op == OP_NOP));
    // R4
    d_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_bubble |=> (d_op == OP_NOP));
    // R2
    lu_trio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_stall |-> (f_stall && e_bubble));
    // R4
    mispred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((e_op == OP_JCC) && !e_cnd) |-> (d_bubble && e_bubble && !d_stall));
    // R5
    ret_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((d_op == OP_RET) || (e_op == OP_RET) || (m_op == OP_RET)) |-> f_stall);
    // R9
    m_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (m_op == $past(e_op)));
endmodule

bind pipe_hazard_ctl hzd_chk u_chk (.*);

// File: tb/sim_pipe_hazard_ctl.sv
module sim_pipe_hazard_ctl;
    localparam int N    = 24;
    localparam int MAXC = 80;
    localparam logic [16:0] NOP17 = 17'h01FFF;
    // [16] jump outcome, [15:12] op, [11:8] src a, [7:4] src b, [3:0] mem dst
    localparam logic [16:0] PROG [N] = '{
        17'h05F32, 17'h0621F, 17'h01FFF, 17'h05F33, 17'h0613F, 17'h0B441,
        17'h0611F, 17'h05F35, 17'h0612F, 17'h07FFF, 17'h0612F, 17'h0634F,
        17'h0944F, 17'h01FFF, 17'h01FFF, 17'h05F34, 17'h0944F, 17'h01FFF,
        17'h07FFF, 17'h0944F, 17'h01FFF, 17'h05FFF, 17'h06FFF, 17'h17FFF};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] f_op = 4'h1, f_src_a = 4'hF, f_src_b = 4'hF, f_dst_m = 4'hF;
    logic e_cnd = 1'b0;
    logic f_stall, d_stall, d_bubble, e_bubble;
    logic [3:0] d_op, e_op, m_op;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pipe_hazard_ctl u0 (.*);

    task automatic check(input bit ok, input string req,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] ctl();
        return {f_stall, d_stall, d_bubble, e_bubble};
    endfunction

    task automatic drive(input logic [15:0] ins, input logic cnd);
        @(negedge clk);
        {f_op, f_src_a, f_src_b, f_dst_m} = ins;
        e_cnd = cnd;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {f_op, f_src_a, f_src_b, f_dst_m} = 16'h1FFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [16:0] rd, re, rm, fi, nre;
        logic        lu, mp, rt, cnd;
        logic [3:0]  ex;
        string       tag;
        int          pc;

        // R10 / R1: reset loads flushed stages
        do_reset();
        #1;
        check({d_op, e_op, m_op} == 12'h111, "R10 reset stages",
              {4'h0, d_op, e_op, m_op}, 16'h0111);
        check(ctl() == 4'b0000, "R1 reset controls", {12'h0, ctl()}, 16'h0);

        // Stream against reference pipeline model (R2..R9)
        rd = NOP17; re = NOP17; rm = NOP17; pc = 0;
        for (int c = 0; c < MAXC; c++) begin
            fi  = (pc < N) ? PROG[pc] : NOP17;
            cnd = (re[15:12] == 4'h7) ? re[16] : c[0];
            drive(fi[15:0], cnd);
            lu = ((re[15:12] == 4'h5) || (re[15:12] == 4'hB)) && (re[3:0] != 4'hF)
                 && ((re[3:0] == rd[11:8]) || (re[3:0] == rd[7:4]));
            mp = (re[15:12] == 4'h7) && !cnd;
            rt = (rd[15:12] == 4'h9) || (re[15:12] == 4'h9) || (rm[15:12] == 4'h9);
            ex = {lu | rt, lu, mp | (rt & !lu), mp | lu};
            tag = (lu && rt) ? "R6 stream" : (mp && rt) ? "R7 stream" :
                  lu ? "R2 stream" : mp ? "R4 stream" : rt ? "R5 stream" : "R9 stream";
            check(ctl() == ex, tag, {12'h0, ctl()}, {12'h0, ex});
            check({d_op, e_op, m_op} == {rd[15:12], re[15:12], rm[15:12]},
                  "R3 stream stage ops", {4'h0, d_op, e_op, m_op},
                  {4'h0, rd[15:12], re[15:12], rm[15:12]});
            @(posedge clk);
            rm  = re;
            nre = ex[0] ? NOP17 : rd;
            if (!ex[2]) rd = ex[1] ? NOP17 : fi;
            re  = nre;
            if (!ex[3]) pc++;
        end

        // R6: load into r4 then return reading r4
        do_reset();
        drive(16'h5F34, 1'b1);
        drive(16'h944F, 1'b1);
        drive(16'h1FFF, 1'b1);
        check(ctl() == 4'b1101, "R6 ret meets load/use", {12'h0, ctl()}, 16'hD);
        drive(16'h1FFF, 1'b1);
        check(d_op == 4'h9 && e_op == 4'h1, "R3 ret held in decode, E bubbled",
              {8'h0, d_op, e_op}, 16'h0091);
        check(ctl() == 4'b1010, "R5 ret stall cycle 1", {12'h0, ctl()}, 16'hA);
        drive(16'h1FFF, 1'b1);
        check(ctl() == 4'b1010, "R5 ret stall cycle 2", {12'h0, ctl()}, 16'hA);
        drive(16'h1FFF, 1'b1);
        check(ctl() == 4'b1010 && m_op == 4'h9, "R5 ret stall cycle 3",
              {8'h0, ctl(), m_op}, 16'h00A9);
        drive(16'h1FFF, 1'b1);
        check(ctl() == 4'b0000, "R5 ret stall ends", {12'h0, ctl()}, 16'h0);

        // R7: not-taken jump then return
        do_reset();
        drive(16'h7FFF, 1'b0);
        drive(16'h944F, 1'b0);
        check(ctl() == 4'b0000, "R9 cnd ignored without jump in E",
              {12'h0, ctl()}, 16'h0);
        drive(16'h1FFF, 1'b0);
        check(ctl() == 4'b1011, "R7 mispredict with ret", {12'h0, ctl()}, 16'hB);
        drive(16'h1FFF, 1'b0);
        check(ctl() == 4'b0000 && d_op == 4'h1 && e_op == 4'h1,
              "R7 ret cancelled", {4'h0, ctl(), d_op, e_op}, 16'h0011);

        // R2: no-register destination never matches
        do_reset();
        drive(16'h5FFF, 1'b1);
        drive(16'h6FFF, 1'b1);
        drive(16'h1FFF, 1'b1);
        check(ctl() == 4'b0000, "R2 null register no hazard", {12'h0, ctl()}, 16'h0);

        // R9: taken jump causes nothing
        do_reset();
        drive(16'h7FFF, 1'b1);
        drive(16'h612F, 1'b1);
        drive(16'h1FFF, 1'b1);
        check(ctl() == 4'b0000, "R9 taken jump no bubble", {12'h0, ctl()}, 16'h0);
        drive(16'h1FFF, 1'b1);
        check(d_op == 4'h1 && e_op == 4'h6 && m_op == 4'h7, "R9 M follows E",
              {4'h0, d_op, e_op, m_op}, 16'h0167);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule